// File: doc/BRIEF.md
# End-of-Write Status Polling Controller

This controller sits on the host side of a flash memory and waits for an already-issued program or erase to finish. Once started with the target address and the byte that should end up there, it reads that location over and over through a single-outstanding read request / read data handshake. It judges each returned byte by one of two status rules, chosen per operation. Under the data-polling rule, bit 7 holds the complement of the expected bit 7 while the write is busy. Under the toggle rule, bit 6 flips on every read while the write is busy.

The nonvolatile write ends at a time unrelated to the reads, so one read can report completed status and still return a byte that differs from the expected one. When that happens the controller does not decide at once. It reads the same location exactly two more times and declares success only if both of those reads return the expected byte. A programmable limit on the number of status reads stops a write that never completes and reports a timeout. The result is a one-cycle done pulse with success and timeout flags that stay valid until the next start.

Top module: `eow_poll_ctrl`

## Requirements
- R1: A start_i pulse seen while busy_o is low captures addr_i, exp_data_i, mode_i and max_polls_i. In the next cycle busy_o is high and rd_req_o pulses for one cycle, with rd_addr_o equal to the captured address.
- R2: At most one read is outstanding. After a rd_req_o pulse, no new request is made until rd_valid_i has been seen, and rd_valid_i is only taken while a read is outstanding.
- R3: With mode_i = 0 (data polling), a returned byte reports completed status when its bit 7 equals bit 7 of the expected byte. Otherwise the write is still busy.
- R4: With mode_i = 1 (toggle), a returned byte reports completed status when its bit 6 equals bit 6 of the previous read of the same operation. The first read of an operation never reports completion.
- R5: A status read that reports completion and returns exactly the expected byte ends the operation with success_o = 1 and timeout_o = 0.
- R6: A status read that reports completion but returns a byte different from the expected one triggers exactly two further reads of the same address. The operation succeeds only if both return the expected byte. Otherwise it ends with success_o = 0 and timeout_o = 0.
- R7: A busy status read that brings the number of status reads in the operation to max_polls_i or more ends the operation with timeout_o = 1 and success_o = 0. The two confirmation reads are not counted, and a limit of 0 acts like 1.
- R8: done_o is high for exactly one cycle, the cycle after the last read data. success_o and timeout_o are set together with done_o, are never both high, hold until the next accepted start, and are cleared by that start.
- R9: start_i while busy_o is high is ignored. The address, the rule in use and the outcome of the running operation do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin waiting for a write to finish |
| addr_i | input | ADDR_W | Location that was written |
| exp_data_i | input | 8 | Byte that location should hold when the write is done |
| mode_i | input | 1 | 0 = data-polling rule, 1 = toggle rule |
| max_polls_i | input | CNT_W | Limit on status reads before timeout |
| rd_req_o | output | 1 | One-cycle read request |
| rd_addr_o | output | ADDR_W | Address of the read |
| rd_valid_i | input | 1 | Read data valid |
| rd_data_i | input | 8 | Read data byte |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| success_o | output | 1 | Last operation found the expected byte |
| timeout_o | output | 1 | Last operation hit the read limit |

## Verification
Data-polling streams are tried where the first read already matches, where bit 7 stays inverted for several reads, and where bit 7 reads as done but other bits still differ. These separate an immediate finish, plain polling and the confirmation path. Toggle streams with alternating, repeated and stuck-equal bit 6 show that the previous read is the reference and that the first read never completes. Confirmation pairs with good/good, good/bad and bad/good results show that both extra reads are always made and that both must match. Runs at the read limit, at a limit of zero, with a stray start mid-operation and with read latencies of zero and several cycles cover the timeout count, the ignored start and the handshake.

// File: rtl/eow_poll_pkg.sv
package eow_poll_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_POLL_REQ,
    ST_POLL_WAIT,
    ST_CONF_REQ,
    ST_CONF_WAIT
  } eow_state_e;

  localparam logic RULE_DATA   = 1'b0;
  localparam logic RULE_TOGGLE = 1'b1;
endpackage

// File: rtl/eow_classify.sv
module eow_classify #(
  parameter int DATA_W = 8
) (
  input  logic              rule_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic [DATA_W-1:0] exp_data_i,
  input  logic              prev_tog_i,
  input  logic              prev_ok_i,
  output logic              stat_done_o,
  output logic              byte_ok_o
);
  import eow_poll_pkg::*;

  localparam int POLL_BIT = DATA_W - 1;
  localparam int TOG_BIT  = DATA_W - 2;

  logic poll_done;
  logic tog_done;

  // data rule: busy while the top bit is the complement of the expected one
  assign poll_done = (rd_data_i[POLL_BIT] == exp_data_i[POLL_BIT]);
  // toggle rule: done once the toggle bit stops moving between two reads
  assign tog_done  = prev_ok_i && (rd_data_i[TOG_BIT] == prev_tog_i);

  assign stat_done_o = (rule_i == RULE_TOGGLE) ? tog_done : poll_done;
  assign byte_ok_o   = (rd_data_i == exp_data_i);
endmodule

// File: rtl/eow_attempt_cnt.sv
module eow_attempt_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             last_o
);
  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic [EXT_W-1:0] cnt_plus;

  assign cnt_en   = clr_i || inc_i;
  assign cnt_d    = clr_i ? '0 : cnt_q + 1'b1;
  assign cnt_plus = {1'b0, cnt_q} + 1'b1;
  // true when the read now being counted reaches the limit
  assign last_o   = (cnt_plus >= {1'b0, limit_i});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/eow_poll_ctrl.sv
module eow_poll_ctrl #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] exp_data_i,
  input  logic              mode_i,
  input  logic [CNT_W-1:0]  max_polls_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_valid_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              success_o,
  output logic              timeout_o
);
  import eow_poll_pkg::*;

  localparam int TOG_BIT = DATA_W - 2;

  eow_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] exp_q;
  logic              rule_q;
  logic [CNT_W-1:0]  limit_q;
  logic              prev_tog_q, prev_tog_d;
  logic              prev_ok_q, prev_ok_d;
  logic              conf_idx_q, conf_idx_d;
  logic              conf_bad_q, conf_bad_d;
  logic              done_q, done_d;
  logic              succ_q, succ_d;
  logic              tout_q, tout_d;
  logic              cap_en;
  logic              cnt_clr, cnt_inc, cnt_last;
  logic              stat_done, byte_ok;

  eow_classify #(.DATA_W(DATA_W)) classify_i (
    .rule_i      (rule_q),
    .rd_data_i   (rd_data_i),
    .exp_data_i  (exp_q),
    .prev_tog_i  (prev_tog_q),
    .prev_ok_i   (prev_ok_q),
    .stat_done_o (stat_done),
    .byte_ok_o   (byte_ok)
  );

  eow_attempt_cnt #(.CNT_W(CNT_W)) attempt_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (cnt_clr),
    .inc_i   (cnt_inc),
    .limit_i (limit_q),
    .last_o  (cnt_last)
  );

  assign cap_en = (state_q == ST_IDLE) && start_i;

  always_comb begin
    state_d    = state_q;
    prev_tog_d = prev_tog_q;
    prev_ok_d  = prev_ok_q;
    conf_idx_d = conf_idx_q;
    conf_bad_d = conf_bad_q;
    succ_d     = succ_q;
    tout_d     = tout_q;
    done_d     = 1'b0;
    cnt_clr    = 1'b0;
    cnt_inc    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d   = ST_POLL_REQ;
          prev_ok_d = 1'b0;
          succ_d    = 1'b0;
          tout_d    = 1'b0;
          cnt_clr   = 1'b1;
        end
      end
      ST_POLL_REQ: state_d = ST_POLL_WAIT;
      ST_POLL_WAIT: begin
        if (rd_valid_i) begin
          cnt_inc    = 1'b1;
          prev_tog_d = rd_data_i[TOG_BIT];
          prev_ok_d  = 1'b1;
          if (stat_done && byte_ok) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
            succ_d  = 1'b1;
          end else if (stat_done) begin
            state_d    = ST_CONF_REQ;
            conf_idx_d = 1'b0;
            conf_bad_d = 1'b0;
          end else if (cnt_last) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
            tout_d  = 1'b1;
          end else begin
            state_d = ST_POLL_REQ;
          end
        end
      end
      ST_CONF_REQ: state_d = ST_CONF_WAIT;
      ST_CONF_WAIT: begin
        if (rd_valid_i) begin
          if (conf_idx_q) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
            succ_d  = !conf_bad_q && byte_ok;
          end else begin
            state_d    = ST_CONF_REQ;
            conf_idx_d = 1'b1;
            conf_bad_d = !byte_ok;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      prev_tog_q <= 1'b0;
      prev_ok_q  <= 1'b0;
      conf_idx_q <= 1'b0;
      conf_bad_q <= 1'b0;
      done_q     <= 1'b0;
      succ_q     <= 1'b0;
      tout_q     <= 1'b0;
    end else begin
      state_q    <= state_d;
      prev_tog_q <= prev_tog_d;
      prev_ok_q  <= prev_ok_d;
      conf_idx_q <= conf_idx_d;
      conf_bad_q <= conf_bad_d;
      done_q     <= done_d;
      succ_q     <= succ_d;
      tout_q     <= tout_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      exp_q   <= '0;
      rule_q  <= RULE_DATA;
      limit_q <= '0;
    end else if (cap_en) begin
      addr_q  <= addr_i;
      exp_q   <= exp_data_i;
      rule_q  <= mode_i;
      limit_q <= max_polls_i;
    end
  end

  assign rd_req_o  = (state_q == ST_POLL_REQ) || (state_q == ST_CONF_REQ);
  assign rd_addr_o = addr_q;
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign success_o = succ_q;
  assign timeout_o = tout_q;
endmodule

// File: rtl/eow_poll_chk.sv
module eow_poll_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              rd_req_o,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              rd_valid_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              success_o,
  input logic              timeout_o
);
  logic pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (rd_req_o) begin
      pend_q <= 1'b1;
    end else if (rd_valid_i) begin
      pend_q <= 1'b0;
    end
  end

  AST_START_ISSUES: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (busy_o && rd_req_o && rd_addr_o == $past(addr_i))); // R1
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |=> !rd_req_o); // R1
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |-> !pend_q); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R8
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(success_o && timeout_o)); // R8
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_o && !$past(start_i && !busy_o)) |-> ($stable(success_o) && $stable(timeout_o))); // R8
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(rd_addr_o)); // R9
endmodule

bind eow_poll_ctrl eow_poll_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .addr_i     (addr_i),
  .rd_req_o   (rd_req_o),
  .rd_addr_o  (rd_addr_o),
  .rd_valid_i (rd_valid_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .success_o  (success_o),
  .timeout_o  (timeout_o)
);

// File: tb/eow_poll_ctrl_tb_top.sv
module eow_poll_ctrl_tb_top;
  localparam int ADDR_W = 24;
  localparam int DATA_W = 8;
  localparam int CNT_W  = 16;

  typedef struct {
    logic  succ;
    logic  tout;
    int    reads;
    string tag;
  } exp_t;

  logic              clk;
  logic              rst_n;
  logic              start_i;
  logic [ADDR_W-1:0] addr_i;
  logic [DATA_W-1:0] exp_data_i;
  logic              mode_i;
  logic [CNT_W-1:0]  max_polls_i;
  logic              rd_req_o;
  logic [ADDR_W-1:0] rd_addr_o;
  logic              rd_valid_i;
  logic [DATA_W-1:0] rd_data_i;
  logic              busy_o;
  logic              done_o;
  logic              success_o;
  logic              timeout_o;

  int checks;
  int errors;
  int done_cnt;
  int read_cnt;
  int lat;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] resp_q[$];
  exp_t              sb_q[$];

  eow_poll_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
    .exp_data_i(exp_data_i), .mode_i(mode_i), .max_polls_i(max_polls_i),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_valid_i(rd_valid_i),
    .rd_data_i(rd_data_i), .busy_o(busy_o), .done_o(done_o),
    .success_o(success_o), .timeout_o(timeout_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input logic ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // read responder: answers each request after lat cycles, checks its address
  initial begin
    logic pend;
    int   dly;
    pend = 1'b0;
    dly  = 0;
    rd_valid_i = 1'b0;
    rd_data_i  = '0;
    forever begin
      @(negedge clk);
      rd_valid_i = 1'b0;
      if (rd_req_o) begin
        chk(!pend, "R2 request while read outstanding", 1, 0);
        chk(rd_addr_o == cur_addr, "R1/R9 read address", int'(rd_addr_o), int'(cur_addr));
        pend = 1'b1;
        dly  = lat;
      end else if (pend) begin
        if (dly == 0) begin
          pend = 1'b0;
          rd_valid_i = 1'b1;
          read_cnt++;
          if (resp_q.size() > 0) rd_data_i = resp_q.pop_front();
          else rd_data_i = 8'h00;
        end else begin
          dly--;
        end
      end
    end
  end

  // monitor: pops the scoreboard on each done pulse
  initial begin
    forever begin
      @(negedge clk);
      if (done_o) begin
        exp_t e;
        done_cnt++;
        if (sb_q.size() == 0) begin
          chk(1'b0, "R8 unexpected done", 1, 0);
        end else begin
          e = sb_q.pop_front();
          chk(success_o == e.succ, {e.tag, " success"}, int'(success_o), int'(e.succ));
          chk(timeout_o == e.tout, {e.tag, " timeout"}, int'(timeout_o), int'(e.tout));
          chk(read_cnt == e.reads, {e.tag, " read count"}, read_cnt, e.reads);
          chk(!(success_o && timeout_o), "R8 flags exclusive", 1, 0);
        end
      end
    end
  end

  task automatic run_op(input logic m, input logic [ADDR_W-1:0] a,
                        input logic [DATA_W-1:0] e, input int lim,
                        input logic [DATA_W-1:0] bytes[$], input logic es,
                        input logic et, input int er, input bit inject,
                        input string tag);
    exp_t x;
    int   prev;
    x.succ = es; x.tout = et; x.reads = er; x.tag = tag;
    sb_q.push_back(x);
    resp_q   = bytes;
    read_cnt = 0;
    cur_addr = a;
    prev     = done_cnt;
    @(negedge clk);
    mode_i = m; addr_i = a; exp_data_i = e; max_polls_i = CNT_W'(lim);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o && !success_o && !timeout_o, "R8 flags cleared by start",
        int'({busy_o, success_o, timeout_o}), 4);
    if (inject) begin
      repeat (2) @(negedge clk);
      addr_i = ~a; mode_i = ~m; max_polls_i = '0;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (done_cnt == prev) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(success_o == es && timeout_o == et, {tag, " R8 flags held"},
        int'({success_o, timeout_o}), int'({es, et}));
    chk(resp_q.size() == 0, {tag, " responses consumed"}, resp_q.size(), 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0; done_cnt = 0; read_cnt = 0; lat = 0;
    cur_addr = '0;
    start_i = 1'b0; addr_i = '0; exp_data_i = '0; mode_i = 1'b0; max_polls_i = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy_o && !rd_req_o && !done_o && !success_o && !timeout_o, "R8 reset state",
        int'({busy_o, rd_req_o, done_o, success_o, timeout_o}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3/R5: data rule, first read already final
    run_op(1'b0, 24'h012345, 8'h5A, 8, '{8'h5A}, 1'b1, 1'b0, 1, 1'b0, "R3 R5 data immediate");
    // R3: bit 7 inverted while busy
    run_op(1'b0, 24'h100000, 8'h5A, 8, '{8'hA5, 8'hDA, 8'h5A}, 1'b1, 1'b0, 3, 1'b0, "R3 data busy then done");
    lat = 3;
    // R6: status done with wrong byte, both confirmations good
    run_op(1'b0, 24'h200010, 8'h5A, 8, '{8'h1A, 8'h5A, 8'h5A}, 1'b1, 1'b0, 3, 1'b0, "R6 confirm good good");
    // R6: second confirmation bad
    run_op(1'b0, 24'h200011, 8'h5A, 8, '{8'h1A, 8'h5A, 8'h1B}, 1'b0, 1'b0, 3, 1'b0, "R6 confirm good bad");
    // R6: first confirmation bad, second still taken
    run_op(1'b0, 24'h200012, 8'h5A, 8, '{8'h1A, 8'h1A, 8'h5A}, 1'b0, 1'b0, 3, 1'b0, "R6 confirm bad good");
    lat = 0;
    // R7: data rule timeout at limit
    run_op(1'b0, 24'h300000, 8'h5A, 4, '{8'hFF, 8'hFF, 8'hFF, 8'hFF}, 1'b0, 1'b1, 4, 1'b0, "R7 data timeout");
    // R7: limit zero acts like one
    run_op(1'b0, 24'h300001, 8'h5A, 0, '{8'hFF}, 1'b0, 1'b1, 1, 1'b0, "R7 zero limit");
    // R4: toggle rule, bit 6 alternates then settles
    run_op(1'b1, 24'h400000, 8'hFF, 8, '{8'h00, 8'h40, 8'hFF}, 1'b1, 1'b0, 3, 1'b0, "R4 toggle settle");
    // R4: first read never completes even when it matches
    run_op(1'b1, 24'h400001, 8'hFF, 8, '{8'hFF, 8'hFF}, 1'b1, 1'b0, 2, 1'b0, "R4 toggle first read");
    // R4/R7: toggle keeps flipping until the limit
    run_op(1'b1, 24'h400002, 8'hFF, 3, '{8'h00, 8'h40, 8'h00}, 1'b0, 1'b1, 3, 1'b0, "R4 R7 toggle timeout");
    // R4/R6: toggle settled on wrong byte, confirmations good
    run_op(1'b1, 24'h400003, 8'hFF, 8, '{8'h40, 8'h40, 8'hFF, 8'hFF}, 1'b1, 1'b0, 4, 1'b0, "R6 toggle confirm");
    lat = 2;
    // R9: stray start during the operation is ignored
    run_op(1'b0, 24'h500000, 8'h5A, 8, '{8'hA5, 8'hDA, 8'h5A}, 1'b1, 1'b0, 3, 1'b1, "R9 start while busy");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule